// File: doc/BRIEF.md
# Gated On-Chip RAM Window

This block places a small static RAM inside a fixed window at the top of a 24-bit address space. A CPU-side access port carries the address, a write strobe, a byte/word size flag and 16-bit data. A local control register holds an enable bit. While that bit is set, an access whose address lies in the window is served by the internal RAM in the same cycle. Every other access, including a window access while the bit is clear, goes out on the external bus port.

Data lanes are big-endian. A byte at an even address travels on bits 15:8 and a byte at an odd address travels on bits 7:0. A word covers both lanes and must be aligned. The control register is eight bits of read/write storage. Bit 0 is the RAM enable. Bits 5:3 hold interrupt-mode and edge-select settings for other logic.

A hardware reset restores the register. A standby input freezes RAM and register contents. The window is 4 KB, from 0xFFEC00 to 0xFFFBFF. A parameter can shrink it to 2 KB, from 0xFFF400 to 0xFFFBFF.

Top module: `ram_window_ctrl`

## Requirements
- R1: During and right after reset, `ctl_rdata` reads 0x01: the enable bit (bit 0) is 1 and bits 7:1 are 0.
- R2: A register write (`ctl_sel`=1, `ctl_we`=1) stores all eight bits of `ctl_wdata`, and `ctl_rdata` shows them from the next cycle.
- R3: With the enable bit set, an access to 0xFFEC00..0xFFFBFF is served internally and `ext_req` stays 0. Internal read data appears on `acc_rdata` in the same cycle.
- R4: An access outside the window, or any access while the enable bit is 0, raises `ext_req`. The port shows the address, `ext_we`, the byte enables and the write data, and `ext_rdata` is returned on `acc_rdata`.
- R5: Both window limits are inclusive. 0xFFEC00 and 0xFFFBFE are internal, while 0xFFEBFF and 0xFFFC00 are external.
- R6: A byte write to an even address writes only bits 15:8 of the word from `acc_wdata[15:8]`. A byte write to an odd address writes only bits 7:0 from `acc_wdata[7:0]`. The other byte keeps its value.
- R7: A word write updates both bytes, and a word read returns the full 16 bits.
- R8: A word access with address bit 0 set is performed at the even address below it and raises `misalign` only during that access cycle. On the external port, `ext_addr` bit 0 is 0 for every word access.
- R9: While `standby`=1, RAM writes and register writes are ignored and `ext_req` stays 0. RAM contents and the register survive.
- R10: A hardware reset returns the register to 0x01 from any value, including a cleared enable bit.
- R11: `ext_be` is 2'b11 for a word access, 2'b10 for an even byte and 2'b01 for an odd byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| standby | input | 1 | Freezes RAM and register state; blocks all accesses |
| acc_req | input | 1 | Access valid this cycle |
| acc_addr | input | 24 | Byte address |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = word, 0 = byte |
| acc_wdata | input | 16 | Write data, big-endian lanes |
| acc_rdata | output | 16 | Read data (internal RAM or external) |
| misalign | output | 1 | Word access at an odd address this cycle |
| ctl_sel | input | 1 | Control register selected |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| ext_req | output | 1 | External bus access this cycle |
| ext_addr | output | 24 | External address |
| ext_we | output | 1 | External write strobe |
| ext_be | output | 2 | External byte enables, bit 1 = bits 15:8 |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |

## Verification
The hardest situation to reach is a write or register update that arrives during standby and must leave no trace. The bench first stores known data and a known register value. It then raises standby and, in the same cycles, drives a word write into the window and a register write that would clear the enable bit. After standby is released it reads both back, and also checks that no external request appeared. A reset of a register with the enable bit cleared is staged the same way, so that R10 is observed from a non-default value.

// File: rtl/ram_win_pkg.sv
// Package: shared constants and helpers for the gated RAM window.
// Assumes a byte-addressed bus with big-endian byte lanes.
package ram_win_pkg;

    localparam int unsigned BUS_AW    = 24;
    localparam int unsigned BUS_DW    = 16;
    localparam int unsigned CTL_W     = 8;
    localparam logic [7:0]  CTL_RESET = 8'h01;
    localparam int unsigned ENABLE_BIT = 0;

    // Byte-enable mask for an access: word -> all lanes, byte -> one lane,
    // lane 0 at the highest data bits (big-endian).
    function automatic logic [BUS_DW/8-1:0] lane_mask(
        input logic word,
        input logic [$clog2(BUS_DW/8)-1:0] lo
    );
        logic [BUS_DW/8-1:0] m;
        if (word) begin
            m = '1;
        end else begin
            m = '0;
            m[BUS_DW/8-1-int'(lo)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ram_win_ctlreg.sv
// Module: control register with hardware reset and standby freeze.
// Assumes: writes take effect at the clock edge; standby blocks writes;
// the reset value comes from a parameter.
module ram_win_ctlreg #(
    parameter int unsigned   W         = 8,
    parameter logic [W-1:0]  RESET_VAL = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         sel,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    // Purpose: hold register value; load on a selected write outside standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= RESET_VAL;
        end else if (sel && we && !standby) begin
            q_r <= wdata;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/ram_win_decode.sv
// Module: address decode for the RAM window.
// Routes each access to the internal RAM or the external port, builds the
// byte-lane mask and flags word accesses at unaligned addresses.
// Assumes: the window ends 0x401 bytes below the top of the address space
// and is 2 KB or 4 KB long.
module ram_win_decode
    import ram_win_pkg::*;
#(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned DATA_W      = 16,
    parameter bit          HALF_WINDOW = 1'b0,
    localparam int unsigned LANES      = DATA_W / 8,
    localparam int unsigned LSW        = $clog2(LANES),
    localparam int unsigned WIN_BYTES  = HALF_WINDOW ? 2048 : 4096,
    localparam int unsigned IW         = $clog2(WIN_BYTES / LANES)
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic              enable,
    input  logic              standby,
    output logic              hit,
    output logic              go_ext,
    output logic              unaligned,
    output logic [LANES-1:0]  be,
    output logic [IW-1:0]     index,
    output logic [ADDR_W-1:0] out_addr
);

    localparam longint unsigned SPACE = longint'(1) << ADDR_W;
    localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(SPACE - 64'd1025);
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(SPACE - 64'd1024 - 64'(WIN_BYTES));

    logic in_win;
    logic low_nz;

    // Purpose: window compare and route selection.
    always_comb begin
        in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);
        hit    = req && enable && in_win && !standby;
        go_ext = req && !hit && !standby;
    end

    // Purpose: alignment check, lane mask and aligned outgoing address.
    always_comb begin
        low_nz    = (addr[LSW-1:0] != '0);
        unaligned = req && word && low_nz;
        be        = lane_mask(word, addr[LSW-1:0]);
        out_addr  = addr;
        if (word) begin
            out_addr[LSW-1:0] = '0;
        end
    end

    // Purpose: word index inside the RAM, relative to the window base.
    always_comb begin
        index = addr[IW+LSW-1:LSW] - WIN_BASE[IW+LSW-1:LSW];
    end

endmodule

// File: rtl/ram_win_store.sv
// Module: RAM storage, one byte-wide array per lane.
// Assumes: one write per cycle under byte enables; reads are asynchronous,
// so data returns in the cycle of the access.
module ram_win_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 2048,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  be,
    input  logic [IW-1:0]     index,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] mem [DEPTH];

        // Purpose: write this lane when it is enabled.
        always_ff @(posedge clk) begin
            if (wr_en && be[l]) begin
                mem[index] <= wdata[l*8 +: 8];
            end
        end

        // Purpose: asynchronous read of this lane.
        always_comb begin
            rdata[l*8 +: 8] = mem[index];
        end
    end

endmodule

// File: rtl/ram_window_ctrl.sv
// Module: top of the gated RAM window.
// Joins the control register, the address decode, the RAM lanes and the
// external port mux. The external outputs are driven only when the access
// is routed outside; otherwise they read zero.
// Assumes: at most one access per cycle; standby is held for whole cycles.
module ram_window_ctrl
    import ram_win_pkg::*;
#(
    parameter int unsigned ADDR_W      = BUS_AW,
    parameter int unsigned DATA_W      = BUS_DW,
    parameter bit          HALF_WINDOW = 1'b0,
    localparam int unsigned LANES      = DATA_W / 8,
    localparam int unsigned WIN_BYTES  = HALF_WINDOW ? 2048 : 4096,
    localparam int unsigned DEPTH      = WIN_BYTES / LANES,
    localparam int unsigned IW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_we,
    input  logic              acc_word,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              misalign,
    input  logic              ctl_sel,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              ext_req,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_we,
    output logic [LANES-1:0]  ext_be,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata
);

    logic [CTL_W-1:0]  ctl_q;
    logic              hit;
    logic              go_ext;
    logic              unaligned;
    logic [LANES-1:0]  be;
    logic [IW-1:0]     index;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] ram_rdata;
    logic              ram_wr;

    ram_win_ctlreg #(
        .W         (CTL_W),
        .RESET_VAL (CTL_RESET)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .sel     (ctl_sel),
        .we      (ctl_we),
        .wdata   (ctl_wdata),
        .q       (ctl_q)
    );

    ram_win_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .HALF_WINDOW (HALF_WINDOW)
    ) u_dec (
        .req       (acc_req),
        .addr      (acc_addr),
        .word      (acc_word),
        .enable    (ctl_q[ENABLE_BIT]),
        .standby   (standby),
        .hit       (hit),
        .go_ext    (go_ext),
        .unaligned (unaligned),
        .be        (be),
        .index     (index),
        .out_addr  (out_addr)
    );

    ram_win_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ram (
        .clk   (clk),
        .wr_en (ram_wr),
        .be    (be),
        .index (index),
        .wdata (acc_wdata),
        .rdata (ram_rdata)
    );

    // Purpose: internal write strobe (decode already excludes standby).
    always_comb begin
        ram_wr = hit && acc_we;
    end

    // Purpose: external port drive, active only on outside routing.
    always_comb begin
        ext_req   = go_ext;
        ext_addr  = go_ext ? out_addr : '0;
        ext_we    = go_ext && acc_we;
        ext_be    = go_ext ? be : '0;
        ext_wdata = go_ext ? acc_wdata : '0;
    end

    // Purpose: read data return and status outputs.
    always_comb begin
        if (hit) begin
            acc_rdata = ram_rdata;
        end else if (go_ext) begin
            acc_rdata = ext_rdata;
        end else begin
            acc_rdata = '0;
        end
        misalign  = unaligned;
        ctl_rdata = ctl_q;
    end

endmodule

// File: rtl/ram_window_chk.sv
// Module: property checker for ram_window_ctrl, attached by bind.
// Observes ports only.
module ram_window_chk #(
    parameter int unsigned ADDR_W      = 24,
    parameter bit          HALF_WINDOW = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              acc_req,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_word,
    input logic              misalign,
    input logic              ctl_sel,
    input logic              ctl_we,
    input logic [7:0]        ctl_wdata,
    input logic [7:0]        ctl_rdata,
    input logic              ext_req,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [1:0]        ext_be
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(24'hFFFBFF);
    localparam logic [ADDR_W-1:0] BASE_A = HALF_WINDOW ? ADDR_W'(24'hFFF400)
                                                       : ADDR_W'(24'hFFEC00);

    // R1 / R10: a reset cycle leaves the register at its default.
    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> ctl_rdata == 8'h01);

    // R2: a register write is visible on the next cycle.
    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sel && ctl_we && !standby) |=> ctl_rdata == $past(ctl_wdata));

    // R3: an enabled window access never uses the external port.
    assert_window_internal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !standby && ctl_rdata[0] && acc_addr >= BASE_A && acc_addr <= LAST_A)
        |-> !ext_req);

    // R4: with the enable bit clear, every access goes outside.
    assert_disabled_external_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !standby && !ctl_rdata[0]) |-> ext_req);

    // R8: the flag only appears on an odd word access.
    assert_misalign_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (acc_req && acc_word && acc_addr[0]));

    // R8: external word addresses are even.
    assert_ext_word_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && acc_word) |-> !ext_addr[0]);

    // R9: no external request during standby.
    assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !ext_req);

    // R9: register holds across a standby cycle.
    assert_standby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ctl_rdata == $past(ctl_rdata));

    // R11: word uses both lanes, byte exactly one.
    assert_word_lanes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && acc_word) |-> ext_be == 2'b11);

    assert_byte_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !acc_word) |-> $countones(ext_be) == 1);

endmodule

bind ram_window_ctrl ram_window_chk #(
    .ADDR_W      (ADDR_W),
    .HALF_WINDOW (HALF_WINDOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .acc_req   (acc_req),
    .acc_addr  (acc_addr),
    .acc_word  (acc_word),
    .misalign  (misalign),
    .ctl_sel   (ctl_sel),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .ext_req   (ext_req),
    .ext_addr  (ext_addr),
    .ext_be    (ext_be)
);

// File: tb/ram_window_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for ram_window_ctrl: one task per scenario.
module ram_window_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        acc_req = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_we = 1'b0;
    logic        acc_word = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        misalign;
    logic        ctl_sel = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        ext_req;
    logic [23:0] ext_addr;
    logic        ext_we;
    logic [1:0]  ext_be;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ram_window_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .acc_req(acc_req), .acc_addr(acc_addr), .acc_we(acc_we),
        .acc_word(acc_word), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .misalign(misalign), .ctl_sel(ctl_sel), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ext_req(ext_req),
        .ext_addr(ext_addr), .ext_we(ext_we), .ext_be(ext_be),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access cycle: drive at negedge, sample 1 ns later, clear next negedge.
    logic [15:0] s_rd;
    logic        s_xreq, s_mis, s_xwe;
    logic [1:0]  s_be;
    logic [23:0] s_xaddr;
    logic [15:0] s_xwd;

    task automatic access(input logic [23:0] a, input logic w, input logic wd,
                          input logic [15:0] d);
        @(negedge clk);
        acc_req = 1'b1; acc_addr = a; acc_we = w; acc_word = wd; acc_wdata = d;
        #1;
        s_rd = acc_rdata; s_xreq = ext_req; s_mis = misalign; s_xwe = ext_we;
        s_be = ext_be; s_xaddr = ext_addr; s_xwd = ext_wdata;
        @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0; acc_word = 1'b0;
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        ctl_sel = 1'b1; ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_sel = 1'b0; ctl_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        #1;
        chk("R1 ctl after reset", 32'(ctl_rdata), 32'h01);
        chk("R1 idle no ext", 32'(ext_req), 32'h0);
    endtask

    task automatic t_ctl_rw();
        ctl_write(8'hFE);
        #1;
        chk("R2 ctl write all bits", 32'(ctl_rdata), 32'hFE);
        ctl_write(8'h39);
        #1;
        chk("R2 ctl write second", 32'(ctl_rdata), 32'h39);
        ctl_write(8'h01);
    endtask

    task automatic t_word();
        access(24'hFFEC00, 1'b1, 1'b1, 16'h1234);
        chk("R3 internal write no ext", 32'(s_xreq), 32'h0);
        access(24'hFFEC00, 1'b0, 1'b1, 16'h0000);
        chk("R7 word readback", 32'(s_rd), 32'h1234);
        chk("R3 internal read no ext", 32'(s_xreq), 32'h0);
    endtask

    task automatic t_bytes();
        access(24'hFFEC10, 1'b1, 1'b1, 16'h0000);
        access(24'hFFEC10, 1'b1, 1'b0, 16'hAB77);
        access(24'hFFEC10, 1'b0, 1'b1, 16'h0);
        chk("R6 even byte upper lane", 32'(s_rd), 32'hAB00);
        access(24'hFFEC11, 1'b1, 1'b0, 16'h66CD);
        access(24'hFFEC10, 1'b0, 1'b1, 16'h0);
        chk("R6 odd byte lower lane", 32'(s_rd), 32'hABCD);
    endtask

    task automatic t_bounds();
        access(24'hFFFBFE, 1'b1, 1'b1, 16'h5A5A);
        chk("R5 top word internal", 32'(s_xreq), 32'h0);
        access(24'hFFFBFE, 1'b0, 1'b1, 16'h0);
        chk("R5 top word data", 32'(s_rd), 32'h5A5A);
        access(24'hFFFC00, 1'b0, 1'b0, 16'h0);
        chk("R5 above window external", 32'(s_xreq), 32'h1);
        access(24'hFFEBFF, 1'b0, 1'b0, 16'h0);
        chk("R5 below window external", 32'(s_xreq), 32'h1);
    endtask

    task automatic t_external();
        access(24'h001235, 1'b1, 1'b0, 16'h00C3);
        chk("R4 ext req", 32'(s_xreq), 32'h1);
        chk("R4 ext addr", 32'(s_xaddr), 32'h001235);
        chk("R4 ext we", 32'(s_xwe), 32'h1);
        chk("R4 ext wdata", 32'(s_xwd), 32'h00C3);
        chk("R11 odd byte be", 32'(s_be), 32'h1);
        ext_rdata = 16'hBEEF;
        access(24'h001234, 1'b0, 1'b0, 16'h0);
        chk("R11 even byte be", 32'(s_be), 32'h2);
        chk("R4 ext read data", 32'(s_rd), 32'hBEEF);
        access(24'h002000, 1'b0, 1'b1, 16'h0);
        chk("R11 word be", 32'(s_be), 32'h3);
    endtask

    task automatic t_disable();
        ctl_write(8'h00);
        ext_rdata = 16'h4321;
        access(24'hFFEC00, 1'b1, 1'b1, 16'hDEAD);
        chk("R4 disabled window goes out", 32'(s_xreq), 32'h1);
        access(24'hFFEC00, 1'b0, 1'b1, 16'h0);
        chk("R4 disabled read from ext", 32'(s_rd), 32'h4321);
        ctl_write(8'h01);
        access(24'hFFEC00, 1'b0, 1'b1, 16'h0);
        chk("R4 RAM untouched while disabled", 32'(s_rd), 32'h1234);
    endtask

    task automatic t_misalign();
        access(24'hFFEC21, 1'b1, 1'b1, 16'h5566);
        chk("R8 flag on odd word", 32'(s_mis), 32'h1);
        #1;
        chk("R8 flag gone next cycle", 32'(misalign), 32'h0);
        access(24'hFFEC20, 1'b0, 1'b1, 16'h0);
        chk("R8 written at even address", 32'(s_rd), 32'h5566);
        chk("R8 no flag on aligned word", 32'(s_mis), 32'h0);
        access(24'h000101, 1'b0, 1'b1, 16'h0);
        chk("R8 ext word addr even", 32'(s_xaddr), 32'h000100);
    endtask

    task automatic t_standby();
        @(negedge clk);
        standby = 1'b1;
        acc_req = 1'b1; acc_addr = 24'hFFEC00; acc_we = 1'b1; acc_word = 1'b1;
        acc_wdata = 16'h9999;
        ctl_sel = 1'b1; ctl_we = 1'b1; ctl_wdata = 8'h38;
        #1;
        chk("R9 no ext in standby", 32'(ext_req), 32'h0);
        @(negedge clk);
        acc_addr = 24'h000010;
        #1;
        chk("R9 outside access blocked", 32'(ext_req), 32'h0);
        chk("R9 ctl frozen", 32'(ctl_rdata), 32'h01);
        @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0; acc_word = 1'b0;
        ctl_sel = 1'b0; ctl_we = 1'b0; standby = 1'b0;
        access(24'hFFEC00, 1'b0, 1'b1, 16'h0);
        chk("R9 RAM kept through standby", 32'(s_rd), 32'h1234);
    endtask

    task automatic t_reset_again();
        ctl_write(8'h38);
        #1;
        chk("R10 pre-reset value", 32'(ctl_rdata), 32'h38);
        do_reset();
        #1;
        chk("R10 reset restores default", 32'(ctl_rdata), 32'h01);
        access(24'hFFEC00, 1'b0, 1'b1, 16'h0);
        chk("R10 window enabled after reset", 32'(s_xreq), 32'h0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_ctl_rw();
        t_word();
        t_bytes();
        t_bounds();
        t_external();
        t_disable();
        t_misalign();
        t_standby();
        t_reset_again();
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule